// File: doc/BRIEF.md
# Nibble-Programmed Bank Register Decoder

This block sits on the CPU write path of a cartridge bank controller and holds the bank registers that are used while the controller runs in its alternate, nibble-programmed mode. Each CPU write in the upper half of the address space is first reduced to an effective address: bits 15:8 are kept, bits 7:2 are cleared, and address lines 3:2 move down into bits 1:0. The effective address then selects one of two full-byte program bank registers, a one-bit mirroring register, one half of one of eight pattern (character) bank registers, or one of four interrupt-timer command strobes.

The outputs are meant to feed the address translation logic directly: four 8 KiB program bank numbers, of which the two upper slots are tied to the last two banks, eight 1 KiB pattern bank numbers and a horizontal/vertical mirroring select. The interrupt timer is not part of this block. Its four commands leave as one-cycle pulses, together with the data byte that came with the write.

Writes only take effect while the alternate-mode input is high. In any other cycle, every register keeps its value.

Top module: `nibble_bank_regs`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), pattern banks 0 to 3 read 0xFF and banks 4 to 7 read 4, 5, 6 and 7. Program banks 0 and 1 read 0x00 and 0x01, mirror_horiz is 0 and tmr_stb is 0.
- R2: A cycle without both wr_en and alt_mode high changes no bank register, no mirroring bit and no strobe.
- R3: A write whose address bits 15:12 are 0x8 loads the whole data byte into program bank 0. Bits 15:12 equal to 0xA load program bank 1. The new value shows on prg_banks in the cycle after the write edge.
- R4: prg_banks[2] always reads 0xFE and prg_banks[3] always reads 0xFF.
- R5: A write whose address bits 15:12 are 0x9 stores data bit 0 as the mirroring bit. mirror_horiz = 1 means horizontal and 0 means vertical.
- R6: A write whose address bits 15:8 lie between 0xB0 and 0xE0 inclusive goes to a pattern bank. Pages 0xB, 0xC, 0xD and 0xE select banks 0/1, 2/3, 4/5 and 6/7 respectively. The odd bank of the pair is chosen when address bit 3 or address bit 11 is set.
- R7: In a pattern-bank write, address bit 2 = 0 replaces bank bits 3:0 with data bits 3:0, and address bit 2 = 1 replaces bank bits 7:4 with data bits 3:0. The other nibble is preserved.
- R8: Writes with address bits 15:8 in 0xE1 to 0xEF or 0xF1 to 0xFF change no register and raise no strobe.
- R9: A write with address bits 15:8 = 0xF0 raises exactly one bit of tmr_stb for one cycle, in the cycle after the write edge. Address bits 3:2 select the bit: 0 is the reload low nibble, 1 the reload high nibble, 2 the control write and 3 the acknowledge. tmr_data carries the written byte in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alt_mode | input | 1 | High while the controller is in nibble-programmed mode |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| prg_banks | output | 4x8 | Program bank numbers for the four 8 KiB slots, index = slot |
| chr_banks | output | 8x8 | Pattern bank numbers for the eight 1 KiB slots, index = slot |
| mirror_horiz | output | 1 | 1 = horizontal mirroring, 0 = vertical |
| tmr_stb | output | 4 | One-cycle timer command pulses: 0 reload low, 1 reload high, 2 control, 3 acknowledge |
| tmr_data | output | 8 | Data byte that goes with a timer strobe |

## Verification
The bench goes after the swizzle first. A decoder that read address bits 1:0 instead of 3:2 would write the wrong nibble or the wrong half of a bank pair, and one that ignored bit 11 would send writes in pages such as 0xB8 to the even bank. It checks the nibble merge: a merge that cleared the other half would wipe the earlier nibble of a two-write bank update. It probes the edges of the pattern range, where a range test on the page nibble alone would let 0xE1 to 0xEF pages corrupt banks 6/7 and 0xF1 pages fire timer strobes. It also checks gating, so writes outside the alternate mode must leave every output untouched.

// File: rtl/nbr_pkg.sv
// Package nbr_pkg
// Shared widths, write-decode types and reset values for the nibble bank
// register decoder. Assumes an 8-bit CPU data bus and a 16-bit address bus.
package nbr_pkg;

    localparam int ADDR_W    = 16;
    localparam int BYTE_W    = 8;
    localparam int NIB_W     = BYTE_W / 2;
    localparam int CHR_REGS  = 8;
    localparam int CHR_IDX_W = $clog2(CHR_REGS);
    localparam int PRG_SLOTS = 4;
    localparam int TMR_CMDS  = 4;
    localparam int TMR_SEL_W = $clog2(TMR_CMDS);

    // Kind of register a write targets
    typedef enum logic [2:0] {
        OP_NONE,
        OP_PRG0,
        OP_PRG1,
        OP_MIRR,
        OP_CHR,
        OP_TIMER
    } wr_op_e;

    // Decoded write: target kind plus the fields each kind needs
    typedef struct packed {
        wr_op_e                 op;
        logic [CHR_IDX_W-1:0]   chr_idx;
        logic                   hi_nib;
        logic [TMR_SEL_W-1:0]   tmr_sel;
    } wr_dec_t;

    // Reset value of pattern bank register i
    function automatic logic [BYTE_W-1:0] chr_reset_val(input int i);
        return (i < CHR_REGS / 2) ? {BYTE_W{1'b1}} : BYTE_W'(i);
    endfunction

endpackage

// File: rtl/nbr_addr_decode.sv
// Module nbr_addr_decode
// Purely combinational. Forms the effective address (bits 15:8 kept,
// bits 7:2 cleared, bits 1:0 taken from address lines 3:2) and classifies
// the write. Assumes the caller qualifies the result with its write enable.
module nbr_addr_decode
    import nbr_pkg::*;
(
    input  logic [ADDR_W-1:0] wr_addr,
    output wr_dec_t           dec
);

    logic [ADDR_W-1:0] eff;
    logic [7:0]        page;
    logic              unused_addr_bits;

    assign eff  = {wr_addr[15:8], 6'b0, wr_addr[3:2]};
    assign page = eff[15:8];
    assign unused_addr_bits = ^{wr_addr[7:4], wr_addr[1:0]};

    // Classify the effective address into a target and its sub-fields
    always_comb begin
        dec         = '0;
        dec.op      = OP_NONE;
        dec.chr_idx = CHR_IDX_W'({eff[13:12], eff[11] | eff[1]} + 3'd2);
        dec.hi_nib  = eff[0];
        dec.tmr_sel = eff[1:0];
        if (page >= 8'hB0 && page <= 8'hE0) begin
            dec.op = OP_CHR;
        end else begin
            case (page[7:4])
                4'h8:    dec.op = OP_PRG0;
                4'h9:    dec.op = OP_MIRR;
                4'hA:    dec.op = OP_PRG1;
                4'hF:    dec.op = (page == 8'hF0) ? OP_TIMER : OP_NONE;
                default: dec.op = OP_NONE;
            endcase
        end
    end

endmodule

// File: rtl/nbr_chr_file.sv
// Module nbr_chr_file
// Eight pattern bank registers, each written one nibble at a time from the
// low data nibble. Assumes wr_go is a single-cycle qualified write pulse.
module nbr_chr_file
    import nbr_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_go,
    input  logic [CHR_IDX_W-1:0]              idx,
    input  logic                              hi_nib,
    input  logic [NIB_W-1:0]                  nib,
    output logic [CHR_REGS-1:0][BYTE_W-1:0]   banks
);

    for (genvar g = 0; g < CHR_REGS; g++) begin : g_bank
        logic [BYTE_W-1:0] r;
        logic              hit;
        assign hit = wr_go && (idx == CHR_IDX_W'(g));

        // Reset to power-up value, else merge the addressed nibble
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                r <= chr_reset_val(g);
            end else if (hit) begin
                if (hi_nib) r <= {nib, r[NIB_W-1:0]};
                else        r <= {r[BYTE_W-1:NIB_W], nib};
            end
        end

        assign banks[g] = r;
    end

endmodule

// File: rtl/nbr_prg_mirror.sv
// Module nbr_prg_mirror
// Two switchable program bank registers and the mirroring bit. The upper
// two program slots are fixed to the last two banks. Assumes single-cycle
// qualified write pulses, at most one of which is high.
module nbr_prg_mirror
    import nbr_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              prg0_go,
    input  logic                              prg1_go,
    input  logic                              mirr_go,
    input  logic [BYTE_W-1:0]                 data,
    output logic [PRG_SLOTS-1:0][BYTE_W-1:0]  prg_banks,
    output logic                              mirror_horiz
);

    logic [BYTE_W-1:0] prg0_q, prg1_q;
    logic              mirr_q;

    // Program bank registers: full-byte loads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prg0_q <= BYTE_W'(0);
            prg1_q <= BYTE_W'(1);
        end else begin
            if (prg0_go) prg0_q <= data;
            if (prg1_go) prg1_q <= data;
        end
    end

    // Mirroring bit: keeps data bit 0 only
    always_ff @(posedge clk) begin
        if (!rst_n)       mirr_q <= 1'b0;
        else if (mirr_go) mirr_q <= data[0];
    end

    assign prg_banks[0] = prg0_q;
    assign prg_banks[1] = prg1_q;
    assign prg_banks[2] = {{(BYTE_W-1){1'b1}}, 1'b0};
    assign prg_banks[3] = {BYTE_W{1'b1}};
    assign mirror_horiz = mirr_q;

endmodule

// File: rtl/nbr_timer_strobe.sv
// Module nbr_timer_strobe
// Turns a qualified timer write into a registered one-hot command pulse
// with the data byte alongside. Assumes wr_go lasts one cycle per write.
module nbr_timer_strobe
    import nbr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_go,
    input  logic [TMR_SEL_W-1:0]  sel,
    input  logic [BYTE_W-1:0]     data,
    output logic [TMR_CMDS-1:0]   stb,
    output logic [BYTE_W-1:0]     stb_data
);

    // Pulse register: one bit per timer command, cleared when idle
    always_ff @(posedge clk) begin
        if (!rst_n)     stb <= '0;
        else if (wr_go) stb <= TMR_CMDS'(1) << sel;
        else            stb <= '0;
    end

    // Data register: captures the byte of the timer write
    always_ff @(posedge clk) begin
        if (!rst_n)     stb_data <= '0;
        else if (wr_go) stb_data <= data;
    end

endmodule

// File: rtl/nibble_bank_regs.sv
// Module nibble_bank_regs
// Top of the nibble-programmed bank register decoder. Qualifies CPU writes
// with the alternate-mode input, decodes the swizzled address and routes
// the write to the pattern file, program/mirroring registers or timer
// strobes. Assumes wr_en is high for exactly one clock per CPU write.
module nibble_bank_regs
    import nbr_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              alt_mode,
    input  logic                              wr_en,
    input  logic [15:0]                       wr_addr,
    input  logic [7:0]                        wr_data,
    output logic [3:0][7:0]                   prg_banks,
    output logic [7:0][7:0]                   chr_banks,
    output logic                              mirror_horiz,
    output logic [3:0]                        tmr_stb,
    output logic [7:0]                        tmr_data
);

    wr_dec_t dec;
    logic    go;

    assign go = wr_en && alt_mode;

    nbr_addr_decode u_dec (
        .wr_addr (wr_addr),
        .dec     (dec)
    );

    nbr_chr_file u_chr (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_go  (go && dec.op == OP_CHR),
        .idx    (dec.chr_idx),
        .hi_nib (dec.hi_nib),
        .nib    (wr_data[NIB_W-1:0]),
        .banks  (chr_banks)
    );

    nbr_prg_mirror u_prg (
        .clk          (clk),
        .rst_n        (rst_n),
        .prg0_go      (go && dec.op == OP_PRG0),
        .prg1_go      (go && dec.op == OP_PRG1),
        .mirr_go      (go && dec.op == OP_MIRR),
        .data         (wr_data),
        .prg_banks    (prg_banks),
        .mirror_horiz (mirror_horiz)
    );

    nbr_timer_strobe u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_go    (go && dec.op == OP_TIMER),
        .sel      (dec.tmr_sel),
        .data     (wr_data),
        .stb      (tmr_stb),
        .stb_data (tmr_data)
    );

endmodule

// File: rtl/nbr_checker.sv
// Module nbr_checker
// Temporal properties of nibble_bank_regs, observed at its ports.
module nbr_checker (
    input logic            clk,
    input logic            rst_n,
    input logic            alt_mode,
    input logic            wr_en,
    input logic [15:0]     wr_addr,
    input logic [7:0]      wr_data,
    input logic [3:0][7:0] prg_banks,
    input logic [7:0][7:0] chr_banks,
    input logic            mirror_horiz,
    input logic [3:0]      tmr_stb
);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && alt_mode) |=> ($stable(prg_banks) && $stable(chr_banks)
                                  && $stable(mirror_horiz) && tmr_stb == 4'b0));

    // R3
    prg0_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && alt_mode && wr_addr[15:12] == 4'h8) |=> prg_banks[0] == $past(wr_data));

    // R3
    prg1_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && alt_mode && wr_addr[15:12] == 4'hA) |=> prg_banks[1] == $past(wr_data));

    // R5
    mirror_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && alt_mode && wr_addr[15:12] == 4'h9) |=> mirror_horiz == $past(wr_data[0]));

    // R9
    stb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tmr_stb));

    // R9
    stb_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|tmr_stb) |-> $past(wr_en && alt_mode && wr_addr[15:8] == 8'hF0));

endmodule

bind nibble_bank_regs nbr_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .alt_mode     (alt_mode),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .prg_banks    (prg_banks),
    .chr_banks    (chr_banks),
    .mirror_horiz (mirror_horiz),
    .tmr_stb      (tmr_stb)
);

// File: tb/sim_nibble_bank_regs.sv
module sim_nibble_bank_regs;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            alt_mode = 1'b0;
    logic            wr_en = 1'b0;
    logic [15:0]     wr_addr = '0;
    logic [7:0]      wr_data = '0;
    logic [3:0][7:0] prg_banks;
    logic [7:0][7:0] chr_banks;
    logic            mirror_horiz;
    logic [3:0]      tmr_stb;
    logic [7:0]      tmr_data;

    int n_run  = 0;
    int n_fail = 0;

    // Reference state built from the requirements
    logic [7:0] m_prg0, m_prg1;
    logic       m_mirr;
    logic [7:0] m_chr [8];
    logic [3:0] m_stb;
    logic [7:0] m_tdat;

    always #2 clk = ~clk;

    nibble_bank_regs u0 (
        .clk(clk), .rst_n(rst_n), .alt_mode(alt_mode), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .prg_banks(prg_banks),
        .chr_banks(chr_banks), .mirror_horiz(mirror_horiz),
        .tmr_stb(tmr_stb), .tmr_data(tmr_data)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_prg0 = 8'h00; m_prg1 = 8'h01; m_mirr = 1'b0;
        for (int i = 0; i < 8; i++) m_chr[i] = (i < 4) ? 8'hFF : 8'(i);
        m_stb = 4'b0; m_tdat = 8'h00;
    endtask

    // R6 table: page nibble picks the pair, bit 3 or bit 11 picks the odd one
    function automatic int pair_base(input logic [3:0] p);
        case (p)
            4'hB: return 0;
            4'hC: return 2;
            4'hD: return 4;
            default: return 6;
        endcase
    endfunction

    task automatic model_write(input logic [15:0] a, input logic [7:0] d, input logic m);
        m_stb = 4'b0;
        if (!m) return;
        if (a[15:8] >= 8'hB0 && a[15:8] <= 8'hE0) begin
            int k;
            k = pair_base(a[15:12]) + ((a[11] || a[3]) ? 1 : 0);
            if (a[2]) m_chr[k][7:4] = d[3:0];
            else      m_chr[k][3:0] = d[3:0];
        end else if (a[15:12] == 4'h8) m_prg0 = d;
        else if (a[15:12] == 4'hA) m_prg1 = d;
        else if (a[15:12] == 4'h9) m_mirr = d[0];
        else if (a[15:8] == 8'hF0) begin
            m_stb = 4'b1 << a[3:2];
            m_tdat = d;
        end
    endtask

    task automatic compare(input string req);
        logic [63:0] ec;
        for (int i = 0; i < 8; i++) ec[i*8 +: 8] = m_chr[i];
        chk({req, " chr"}, chr_banks, ec);
        chk({req, " prg"}, {32'h0, prg_banks}, {32'h0, 8'hFF, 8'hFE, m_prg1, m_prg0});
        chk({req, " mirr"}, {63'h0, mirror_horiz}, {63'h0, m_mirr});
        chk({req, " stb"}, {60'h0, tmr_stb}, {60'h0, m_stb});
        if (m_stb != 4'b0) chk({req, " tdata"}, {56'h0, tmr_data}, {56'h0, m_tdat});
    endtask

    // One write cycle; results are sampled on the next falling edge
    task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic m, input string req);
        @(negedge clk);
        wr_addr = a; wr_data = d; alt_mode = m; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        model_write(a, d, m);
        compare(req);
    endtask

    task automatic idle(input string req);
        @(negedge clk);
        m_stb = 4'b0;
        compare(req);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        logic [15:0] a;
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1 reset");

        // R3 / R5 full byte loads
        wr(16'h8000, 8'hA5, 1'b1, "R3 prg0");
        wr(16'hA7FF, 8'h3C, 1'b1, "R3 prg1");
        wr(16'h9123, 8'h01, 1'b1, "R5 horiz");
        wr(16'h9000, 8'hFE, 1'b1, "R5 vert");
        // R4 fixed slots survive other activity
        chk("R4 slot2", {56'h0, prg_banks[2]}, {56'h0, 8'hFE});
        chk("R4 slot3", {56'h0, prg_banks[3]}, {56'h0, 8'hFF});

        // R6 / R7 every pattern slot by low then high nibble
        for (int s = 0; s < 8; s++) begin
            logic [15:0] base;
            base = {4'hB + 4'(s / 2), 12'h000} | ((s % 2) ? 16'h0008 : 16'h0000);
            wr(base, 8'hF0 | 8'(s), 1'b1, "R7 low nibble");
            wr(base | 16'h0004, 8'h09 ^ 8'(s), 1'b1, "R7 high nibble");
        end
        // R6 bit 11 picks odd bank
        wr(16'hB800, 8'h05, 1'b1, "R6 bit11 odd");
        wr(16'hE000, 8'h0C, 1'b1, "R6 top of range");
        // R8 pages just past the pattern range and past the timer page
        wr(16'hE100, 8'h07, 1'b1, "R8 page E1");
        wr(16'hEF0C, 8'h07, 1'b1, "R8 page EF");
        wr(16'hF100, 8'h07, 1'b1, "R8 page F1");
        // R9 each strobe, then quiet
        for (int c = 0; c < 4; c++) begin
            wr(16'hF000 | 16'(c << 2), 8'h40 + 8'(c), 1'b1, "R9 strobe");
            idle("R9 strobe drop");
        end
        // R2 mode gate
        wr(16'h8000, 8'h11, 1'b0, "R2 prg gated");
        wr(16'hC004, 8'h0E, 1'b0, "R2 chr gated");
        wr(16'hF00C, 8'h0E, 1'b0, "R2 strobe gated");

        // Constrained random mix over the upper address half
        for (int i = 0; i < 3000; i++) begin
            a = 16'($urandom);
            a[15] = 1'b1;
            if (($urandom % 4) == 0) a[15:8] = 8'hF0;
            wr(a, 8'($urandom), (($urandom % 8) != 0), "R6 R7 random");
            if (($urandom % 5) == 0) idle("R2 random idle");
        end

        // R1 reset again after traffic
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        compare("R1 re-reset");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule